// File: doc/BRIEF.md
# Exception Condition and Vector Selector

This block sits beside a processor core's completion logic. Every cycle it looks at the core's exception sources and decides whether an exception is due. The sources are reset requests, bus and memory error reports, interrupt pins, monitor flags, the decrementer register, completion status of the next instruction and the machine-state enable bits. Each source is qualified by its own enable. The surviving requests are ranked by a fixed priority, and the block reports the winner as a cause code and a 20-bit vector offset.

The result is offered on a valid/ready output. `exc_valid` is high in any cycle that has a qualified request. `exc_cause` and `exc_vector` name the highest-ranked one. A transfer happens on a cycle where `exc_valid` and `exc_ready` are both high. While `exc_ready` is low, nothing is consumed.

Level-driven sources are not held by the block. They are reported for as long as their inputs stay active, so the payload may change under back-pressure when the inputs change. The only stored request is the decrementer event. It waits through any number of stalled cycles and is dropped only when it is transferred or when reset occurs.

Top module: `exc_vector_sel`

## Requirements
- R1: The cause code and vector offset are paired as follows: 1 reset 0x00100, 2 machine check 0x00200, 3 instruction breakpoint 0x01300, 4 system call 0x00C00, 5 program 0x00700, 6 trace 0x00D00, 7 system management 0x01400, 8 external 0x00500, 9 thermal 0x01700, 10 performance monitor 0x00F00, 11 decrementer 0x00900. Cause 0 means nothing is pending and comes with vector 0. Offset 0x00E00 is never output.
- R2: While `hreset`, `sreset` or `por` is high, the block reports cause 1. During that time the stored decrementer request is cleared and the stored decrementer top bit is forced to 0.
- R3: Machine check is requested by `tea` together with `dbus_busy`, by `mcp`, or by any of `addr_dbe`, `data_dbe` or `l2_dbe`. It is requested only while `msr_me` is 1.
- R4: External (`ext_int`), system-management (`smi`) and thermal (`therm_over`) requests are each taken only while `msr_ee` is 1.
- R5: A decrementer request is stored when bit DEC_W-1 of `dec_value` is 1 in a cycle where that bit was 0 in the previous cycle, and `msr_ee` is 1. The request stays until it is transferred, and is cleared on transfer. If the bit stays high, no new request is made.
- R6: The instruction breakpoint is requested when `iabr_addr[29:0]` equals `next_ea[31:2]`, `iabr_te` equals `msr_ir`, and `iabr_be` is 1.
- R7: Trace is requested when `instr_done` is high and `instr_isync` is low, and either `msr_se` is 1 or both `instr_branch` and `msr_be` are 1. An instruction-synchronize completion never causes trace.
- R8: The performance-monitor request is `pmc_limit` qualified by `pmc_int_en`.
- R9: System call (`sc_exec`) and program (`prog_req`) requests are not gated by any enable.
- R10: Priority, highest first, is reset, machine check, breakpoint, system call, program, trace, system management, external, thermal, performance monitor, decrementer. Only the highest pending request is reported.
- R11: `exc_valid` is high exactly when some request is qualified, and is low after `rst_n` reset with idle inputs. A transfer is `exc_valid` and `exc_ready` both high. A level request stays reported while its inputs stay active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| hreset | input | 1 | Hard reset request |
| sreset | input | 1 | Soft reset request |
| por | input | 1 | Power-on reset request |
| tea | input | 1 | Transfer-error acknowledge |
| dbus_busy | input | 1 | Data-bus transaction in progress |
| mcp | input | 1 | Machine-check pin |
| addr_dbe | input | 1 | Address double-bit error |
| data_dbe | input | 1 | Data double-bit error |
| l2_dbe | input | 1 | Second-level cache double-bit error |
| ext_int | input | 1 | External interrupt pin |
| smi | input | 1 | System-management pin |
| therm_over | input | 1 | Junction temperature above threshold |
| pmc_limit | input | 1 | Performance counter reached its limit |
| pmc_int_en | input | 1 | Counter interrupt enable |
| dec_value | input | DEC_W | Decrementer register value |
| next_ea | input | 32 | Effective address of the next instruction to complete |
| instr_done | input | 1 | An instruction completes this cycle |
| instr_branch | input | 1 | The completing instruction is a branch |
| instr_isync | input | 1 | The completing instruction is an instruction-synchronize |
| sc_exec | input | 1 | System call executed |
| prog_req | input | 1 | Program exception condition |
| iabr_addr | input | 30 | Breakpoint address, word granular |
| iabr_te | input | 1 | Breakpoint translation bit |
| iabr_be | input | 1 | Breakpoint enable |
| msr_me | input | 1 | Machine-check enable |
| msr_ee | input | 1 | External-interrupt enable |
| msr_se | input | 1 | Single-step trace enable |
| msr_be | input | 1 | Branch trace enable |
| msr_ir | input | 1 | Instruction relocation enabled |
| exc_ready | input | 1 | Consumer accepts the exception |
| exc_valid | output | 1 | An exception is pending |
| exc_vector | output | 20 | Vector offset of the pending exception |
| exc_cause | output | 4 | Cause code of the pending exception |

## Verification
The hardest case is a stored decrementer event that has to survive. Getting there takes a 0-to-1 transition of the top bit with `msr_ee` high. The event is then held back, either by a stalled `exc_ready` or by higher-ranked level requests. Afterwards it must be dropped exactly once, and the still-high bit must not raise it again. Directed stimulus does this: it holds the top bit high across stalls and across masking interrupts, and it also tries edges with `msr_ee` low and edges during reset. Biased random phases then toggle the top bit while other requests compete. The bench's reference model follows the stored event cycle by cycle.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;
  localparam int unsigned VEC_W  = 20;
  localparam int unsigned CAU_W  = 4;
  localparam int unsigned NSRC   = 11;
  localparam int unsigned IDX_W  = $clog2(NSRC);

  // Rank index (0 = highest priority); cause code is rank + 1.
  typedef enum logic [CAU_W-1:0] {
    CAUSE_NONE    = 4'd0,
    CAUSE_RESET   = 4'd1,
    CAUSE_MCHK    = 4'd2,
    CAUSE_IBRK    = 4'd3,
    CAUSE_SYSCALL = 4'd4,
    CAUSE_PROG    = 4'd5,
    CAUSE_TRACE   = 4'd6,
    CAUSE_SMI     = 4'd7,
    CAUSE_EXT     = 4'd8,
    CAUSE_THERM   = 4'd9,
    CAUSE_PMON    = 4'd10,
    CAUSE_DEC     = 4'd11
  } cause_e;

  localparam int unsigned RK_RESET = 0;
  localparam int unsigned RK_MCHK  = 1;
  localparam int unsigned RK_IBRK  = 2;
  localparam int unsigned RK_SC    = 3;
  localparam int unsigned RK_PROG  = 4;
  localparam int unsigned RK_TRACE = 5;
  localparam int unsigned RK_SMI   = 6;
  localparam int unsigned RK_EXT   = 7;
  localparam int unsigned RK_THERM = 8;
  localparam int unsigned RK_PMON  = 9;
  localparam int unsigned RK_DEC   = 10;

  function automatic cause_e cause_of_rank(input logic [IDX_W-1:0] rank);
    return cause_e'(CAU_W'(rank) + CAU_W'(1));
  endfunction

  function automatic logic [VEC_W-1:0] vector_of(input cause_e c);
    logic [VEC_W-1:0] v;
    case (c)
      CAUSE_RESET:   v = 20'h00100;
      CAUSE_MCHK:    v = 20'h00200;
      CAUSE_IBRK:    v = 20'h01300;
      CAUSE_SYSCALL: v = 20'h00C00;
      CAUSE_PROG:    v = 20'h00700;
      CAUSE_TRACE:   v = 20'h00D00;
      CAUSE_SMI:     v = 20'h01400;
      CAUSE_EXT:     v = 20'h00500;
      CAUSE_THERM:   v = 20'h01700;
      CAUSE_PMON:    v = 20'h00F00;
      CAUSE_DEC:     v = 20'h00900;
      default:       v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/exc_qualify.sv
module exc_qualify
  import exc_sel_pkg::*;
#(
  parameter int unsigned EA_W  = 32,
  parameter int unsigned BRK_W = 30
) (
  input  logic             any_reset,
  input  logic             tea,
  input  logic             dbus_busy,
  input  logic             mcp,
  input  logic             addr_dbe,
  input  logic             data_dbe,
  input  logic             l2_dbe,
  input  logic             ext_int,
  input  logic             smi,
  input  logic             therm_over,
  input  logic             pmc_limit,
  input  logic             pmc_int_en,
  input  logic             dec_pend,
  input  logic [EA_W-1:0]  next_ea,
  input  logic             instr_done,
  input  logic             instr_branch,
  input  logic             instr_isync,
  input  logic             sc_exec,
  input  logic             prog_req,
  input  logic [BRK_W-1:0] iabr_addr,
  input  logic             iabr_te,
  input  logic             iabr_be,
  input  logic             msr_me,
  input  logic             msr_ee,
  input  logic             msr_se,
  input  logic             msr_be,
  input  logic             msr_ir,
  output logic [NSRC-1:0]  req
);
  localparam int unsigned LSB = EA_W - BRK_W;

  logic mchk_src, addr_hit, brk_hit, trace_hit;

  always_comb begin
    mchk_src  = (tea & dbus_busy) | mcp | addr_dbe | data_dbe | l2_dbe;
    addr_hit  = (next_ea[EA_W-1:LSB] == iabr_addr);
    brk_hit   = iabr_be & addr_hit & (iabr_te == msr_ir);
    trace_hit = instr_done & ~instr_isync & (msr_se | (msr_be & instr_branch));
  end

  always_comb begin
    req           = '0;
    req[RK_RESET] = any_reset;
    req[RK_MCHK]  = msr_me & mchk_src;
    req[RK_IBRK]  = brk_hit;
    req[RK_SC]    = sc_exec;
    req[RK_PROG]  = prog_req;
    req[RK_TRACE] = trace_hit;
    req[RK_SMI]   = msr_ee & smi;
    req[RK_EXT]   = msr_ee & ext_int;
    req[RK_THERM] = msr_ee & therm_over;
    req[RK_PMON]  = pmc_int_en & pmc_limit;
    req[RK_DEC]   = dec_pend;
  end
endmodule

// File: rtl/exc_dec_track.sv
module exc_dec_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dec_msb,
  input  logic msr_ee,
  input  logic accept,
  output logic pend
);
  logic msb_q;
  logic edge_seen;

  always_comb edge_seen = ~msb_q & dec_msb & msr_ee;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q <= 1'b0;
      pend  <= 1'b0;
    end else if (clr) begin
      msb_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      msb_q <= dec_msb;
      if (edge_seen)   pend <= 1'b1;
      else if (accept) pend <= 1'b0;
    end
  end

  AST_DEC_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !edge_seen) |=> !pend) else $error("dec not cleared"); // R5
  AST_DEC_NEEDS_EE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(msr_ee) && $past(dec_msb)) else $error("dec without edge"); // R5
  AST_DEC_RESET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend) else $error("dec kept in reset"); // R2
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int unsigned N   = 11,
  parameter int unsigned IW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]     = req[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | req[g];
  end
  assign any = blocked[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (grant[i]) idx = IW'(i);
    end
  end

  always_comb begin
    if (!$isunknown(req)) begin
      AST_GRANT_ONEHOT: assert ($onehot0(grant) && (any == (grant != '0)))
        else $error("grant not one-hot"); // R10
    end
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_sel_pkg::*;
#(
  parameter int unsigned DEC_W = 32,
  parameter int unsigned EA_W  = 32,
  parameter int unsigned BRK_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hreset,
  input  logic             sreset,
  input  logic             por,
  input  logic             tea,
  input  logic             dbus_busy,
  input  logic             mcp,
  input  logic             addr_dbe,
  input  logic             data_dbe,
  input  logic             l2_dbe,
  input  logic             ext_int,
  input  logic             smi,
  input  logic             therm_over,
  input  logic             pmc_limit,
  input  logic             pmc_int_en,
  input  logic [DEC_W-1:0] dec_value,
  input  logic [EA_W-1:0]  next_ea,
  input  logic             instr_done,
  input  logic             instr_branch,
  input  logic             instr_isync,
  input  logic             sc_exec,
  input  logic             prog_req,
  input  logic [BRK_W-1:0] iabr_addr,
  input  logic             iabr_te,
  input  logic             iabr_be,
  input  logic             msr_me,
  input  logic             msr_ee,
  input  logic             msr_se,
  input  logic             msr_be,
  input  logic             msr_ir,
  input  logic             exc_ready,
  output logic             exc_valid,
  output logic [VEC_W-1:0] exc_vector,
  output logic [CAU_W-1:0] exc_cause
);
  logic            any_reset;
  logic            dec_pend;
  logic            dec_accept;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic [IDX_W-1:0] win_idx;
  logic            win_any;
  cause_e          win_cause;

  assign any_reset = hreset | sreset | por;

  exc_qualify #(.EA_W(EA_W), .BRK_W(BRK_W)) u_qual (
    .any_reset    (any_reset),
    .tea          (tea),
    .dbus_busy    (dbus_busy),
    .mcp          (mcp),
    .addr_dbe     (addr_dbe),
    .data_dbe     (data_dbe),
    .l2_dbe       (l2_dbe),
    .ext_int      (ext_int),
    .smi          (smi),
    .therm_over   (therm_over),
    .pmc_limit    (pmc_limit),
    .pmc_int_en   (pmc_int_en),
    .dec_pend     (dec_pend),
    .next_ea      (next_ea),
    .instr_done   (instr_done),
    .instr_branch (instr_branch),
    .instr_isync  (instr_isync),
    .sc_exec      (sc_exec),
    .prog_req     (prog_req),
    .iabr_addr    (iabr_addr),
    .iabr_te      (iabr_te),
    .iabr_be      (iabr_be),
    .msr_me       (msr_me),
    .msr_ee       (msr_ee),
    .msr_se       (msr_se),
    .msr_be       (msr_be),
    .msr_ir       (msr_ir),
    .req          (req)
  );

  exc_prio_arb #(.N(NSRC), .IW(IDX_W)) u_arb (
    .req   (req),
    .grant (grant),
    .idx   (win_idx),
    .any   (win_any)
  );

  assign dec_accept = grant[RK_DEC] & exc_ready;

  exc_dec_track u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (any_reset),
    .dec_msb (dec_value[DEC_W-1]),
    .msr_ee  (msr_ee),
    .accept  (dec_accept),
    .pend    (dec_pend)
  );

  always_comb begin
    win_cause  = win_any ? cause_of_rank(win_idx) : CAUSE_NONE;
    exc_valid  = win_any;
    exc_cause  = win_cause;
    exc_vector = vector_of(win_cause);
  end

  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hreset || sreset || por) |-> (exc_valid && exc_cause == CAUSE_RESET))
    else $error("reset not reported"); // R2
  AST_NO_E00: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vector != 20'h00E00) else $error("forbidden vector"); // R1
  AST_ME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause == CAUSE_MCHK) |-> msr_me) else $error("mchk ungated"); // R3
  AST_EE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && (exc_cause == CAUSE_EXT || exc_cause == CAUSE_SMI ||
     exc_cause == CAUSE_THERM)) |-> msr_ee) else $error("ee ungated"); // R4
  AST_TRACE_NOT_ISYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause == CAUSE_TRACE) |-> (instr_done && !instr_isync))
    else $error("trace on isync"); // R7
  AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> (exc_cause == CAUSE_NONE && exc_vector == '0))
    else $error("idle payload"); // R11
endmodule

// File: tb/tb_exc_vector_sel.sv
`timescale 1ns/1ps
module tb_exc_vector_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hreset = 0, sreset = 0, por = 0, tea = 0, dbus_busy = 0, mcp = 0;
  logic addr_dbe = 0, data_dbe = 0, l2_dbe = 0, ext_int = 0, smi = 0, therm_over = 0;
  logic pmc_limit = 0, pmc_int_en = 0;
  logic [31:0] dec_value = 32'h0;
  logic [31:0] next_ea = 32'h0;
  logic instr_done = 0, instr_branch = 0, instr_isync = 0, sc_exec = 0, prog_req = 0;
  logic [29:0] iabr_addr = 30'h3FFFFFFF;
  logic iabr_te = 0, iabr_be = 0, msr_me = 0, msr_ee = 0, msr_se = 0, msr_be = 0, msr_ir = 0;
  logic exc_ready = 0;
  logic exc_valid;
  logic [19:0] exc_vector;
  logic [3:0] exc_cause;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_pend = 0, m_prev = 0;
  bit e_valid;
  int e_cause;
  logic [19:0] e_vec;

  always #2.5 clk = ~clk;

  exc_vector_sel dut (.*);

  function automatic logic [19:0] vec_for(int c);
    logic [19:0] t [12] = '{20'h0, 20'h00100, 20'h00200, 20'h01300, 20'h00C00,
      20'h00700, 20'h00D00, 20'h01400, 20'h00500, 20'h01700, 20'h00F00, 20'h00900};
    return t[c];
  endfunction

  function automatic string tag_for(int c);
    string t [12] = '{"R11", "R2", "R3", "R6", "R9", "R9", "R7", "R4", "R4", "R4", "R8", "R5"};
    return t[c];
  endfunction

  // Reference: expected cause from current inputs and model state.
  task automatic model_eval();
    bit rst_any = hreset | sreset | por;
    e_cause = 0;
    if (rst_any) e_cause = 1;
    else if (msr_me && ((tea && dbus_busy) || mcp || addr_dbe || data_dbe || l2_dbe)) e_cause = 2;
    else if (iabr_be && iabr_te == msr_ir && iabr_addr == next_ea[31:2]) e_cause = 3;
    else if (sc_exec) e_cause = 4;
    else if (prog_req) e_cause = 5;
    else if (instr_done && !instr_isync && (msr_se || (msr_be && instr_branch))) e_cause = 6;
    else if (msr_ee && smi) e_cause = 7;
    else if (msr_ee && ext_int) e_cause = 8;
    else if (msr_ee && therm_over) e_cause = 9;
    else if (pmc_int_en && pmc_limit) e_cause = 10;
    else if (m_pend) e_cause = 11;
    e_valid = (e_cause != 0);
    e_vec = vec_for(e_cause);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= 0; m_prev <= 0;
    end else begin
      model_eval();
      if (hreset || sreset || por) begin
        m_pend <= 0; m_prev <= 0;
      end else begin
        if (!m_prev && dec_value[31] && msr_ee) m_pend <= 1;
        else if (e_cause == 11 && exc_ready) m_pend <= 0;
        m_prev <= dec_value[31];
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      model_eval();
      checks++;
      if (exc_valid !== e_valid || exc_cause !== 4'(e_cause) || exc_vector !== e_vec
          || exc_vector === 20'h00E00) begin
        fails++;
        $display("FAIL %s R1 R10 R11: got v=%0b cause=%0d vec=%05h, expected v=%0b cause=%0d vec=%05h",
                 tag_for(e_cause), exc_valid, exc_cause, exc_vector, e_valid, e_cause, e_vec);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle();
    {hreset, sreset, por, tea, dbus_busy, mcp, addr_dbe, data_dbe, l2_dbe} = '0;
    {ext_int, smi, therm_over, pmc_limit, pmc_int_en} = '0;
    {instr_done, instr_branch, instr_isync, sc_exec, prog_req, iabr_be} = '0;
    {msr_me, msr_ee, msr_se, msr_be} = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1; step(2);                         // R11 idle after reset
    // R2: each reset source, with a decrementer edge arriving during reset
    por = 1; msr_ee = 1; dec_value = 32'h8000_0000; step(2); por = 0; step(1);
    dec_value = 0; step(1);
    hreset = 1; mcp = 1; msr_me = 1; step(2); hreset = 0; step(1);   // R3 after reset
    sreset = 1; step(1); sreset = 0; mcp = 0; step(1);
    // R3: gating by msr_me and each error input
    msr_me = 0; addr_dbe = 1; step(1); msr_me = 1; step(1); addr_dbe = 0;
    data_dbe = 1; step(1); data_dbe = 0; l2_dbe = 1; step(1); l2_dbe = 0;
    tea = 1; step(1); dbus_busy = 1; step(1); tea = 0; dbus_busy = 0; step(1);
    // R4: ee gating
    msr_ee = 0; ext_int = 1; smi = 1; therm_over = 1; step(2);
    msr_ee = 1; step(1); smi = 0; step(1); ext_int = 0; step(1); therm_over = 0; step(1);
    // R8
    pmc_limit = 1; step(1); pmc_int_en = 1; step(1); pmc_limit = 0; step(1);
    // R5: edge without ee, then with ee under stall and masking
    msr_ee = 0; dec_value = 32'h7FFF_FFFF; step(1); dec_value = 32'h8000_0000; step(2);
    msr_ee = 1; step(2);                        // level high, no new event
    dec_value = 32'h7FFF_FFFF; step(1);
    exc_ready = 0; dec_value = 32'h8000_0001; step(3);  // held while stalled
    ext_int = 1; exc_ready = 1; step(2); ext_int = 0; step(1); // masked, kept
    step(3);                                    // accepted once, not raised again
    exc_ready = 0; dec_value = 0; step(1); dec_value = 32'hFFFF_0000; step(1);
    hreset = 1; step(1); hreset = 0; step(2);   // R2 clears event
    // R6: breakpoint
    next_ea = 32'h0000_1234; iabr_addr = 30'h0000_048D; iabr_be = 1; msr_ir = 0; iabr_te = 0; step(1);
    iabr_te = 1; step(1); msr_ir = 1; step(1); iabr_addr = 30'h0000_048C; step(1);
    iabr_be = 0; iabr_addr = 30'h0000_048D; step(1);
    // R7: trace and isync
    instr_done = 1; msr_se = 1; step(1); instr_isync = 1; step(1);
    msr_se = 0; msr_be = 1; instr_branch = 1; step(1); instr_isync = 0; step(1);
    instr_branch = 0; step(1); instr_done = 0; msr_be = 0;
    // R9 and R10: stacked requests peeled from top
    sc_exec = 1; prog_req = 1; instr_done = 1; msr_se = 1; smi = 1; ext_int = 1;
    therm_over = 1; pmc_int_en = 1; pmc_limit = 1; iabr_be = 1; mcp = 1; msr_me = 1; step(1);
    mcp = 0; step(1); iabr_be = 0; step(1); sc_exec = 0; step(1); prog_req = 0; step(1);
    msr_se = 0; step(1); smi = 0; step(1); ext_int = 0; step(1); therm_over = 0; step(1);
    pmc_limit = 0; step(1);
    idle(); step(2);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      hreset = ($urandom_range(0, 99) == 0); sreset = ($urandom_range(0, 149) == 0);
      por = ($urandom_range(0, 199) == 0);
      tea = $urandom_range(0, 9) == 0; dbus_busy = $urandom_range(0, 1) == 0;
      mcp = $urandom_range(0, 19) == 0; addr_dbe = $urandom_range(0, 29) == 0;
      data_dbe = $urandom_range(0, 29) == 0; l2_dbe = $urandom_range(0, 29) == 0;
      ext_int = $urandom_range(0, 5) == 0; smi = $urandom_range(0, 9) == 0;
      therm_over = $urandom_range(0, 9) == 0; pmc_limit = $urandom_range(0, 7) == 0;
      pmc_int_en = $urandom_range(0, 1) == 0;
      msr_me = $urandom_range(0, 1) == 0; msr_ee = $urandom_range(0, 3) != 0;
      msr_se = $urandom_range(0, 7) == 0; msr_be = $urandom_range(0, 1) == 0;
      msr_ir = $urandom_range(0, 1) == 0; iabr_te = $urandom_range(0, 1) == 0;
      iabr_be = $urandom_range(0, 3) == 0;
      instr_done = $urandom_range(0, 2) == 0; instr_branch = $urandom_range(0, 2) == 0;
      instr_isync = $urandom_range(0, 4) == 0;
      sc_exec = $urandom_range(0, 24) == 0; prog_req = $urandom_range(0, 24) == 0;
      next_ea = $urandom; iabr_addr = ($urandom_range(0, 1) == 0) ? next_ea[31:2] : 30'($urandom);
      if ($urandom_range(0, 3) == 0) dec_value = {~dec_value[31], 31'($urandom)};
      exc_ready = $urandom_range(0, 2) != 0;
      step(1);
    end
    idle(); step(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule